// File: doc/BRIEF.md
# Integer Operate Unit

This block runs register-to-register integer and logical operations for a 64-bit datapath. A 32-bit instruction word is offered together with an issue strobe. The unit decodes the fields and reads two sources from a 32-entry register file. It computes the result and writes it to the destination register. The second operand is either a register or an 8-bit unsigned literal carried inside the instruction. The top register index is hardwired to zero: it reads as zero and keeps no value.

Control is a two-state machine. `S_IDLE` waits for work. An issue seen in `S_IDLE` latches the instruction and takes the transition ACCEPT into `S_EXEC`. In `S_EXEC` the unit reads operands, runs the ALU and writes the register file at the closing clock edge. It then always takes the transition RETIRE back to `S_IDLE`. The outputs are registered. In the cycle after `S_EXEC`, `done_o` pulses and `result_o` and `illegal_o` show the outcome. Any opcode or function code outside the supported set raises the illegal flag and leaves the register file untouched.

Top module: `iop_unit`

## Requirements
- R1: Instruction fields: major opcode bits 31:26, first source index bits 25:21, second source index bits 20:16, literal bits 20:13, literal-select bit 12, function code bits 11:5, destination index bits 4:0.
- R2: Register 31 always reads as zero, and a result aimed at register 31 is discarded. The result still appears on `result_o`.
- R3: With bit 12 set, the literal in bits 20:13 is zero-extended to 64 bits and used in place of the second source register.
- R4: Opcode 0x10 with function 0x20 adds and with function 0x29 subtracts (first minus second). Both wrap modulo 2^64.
- R5: Opcode 0x10 with function 0x2D writes 1 when the operands are equal and 0 otherwise.
- R6: Opcode 0x11 selects a logical function by its function code: 0x00 AND, 0x08 AND-NOT (a & ~b), 0x20 OR, 0x28 OR-NOT (a | ~b), 0x40 XOR, 0x48 XOR-NOT (a ^ ~b).
- R7: An issue accepted at a rising edge in `S_IDLE` is written to the register file at the next rising edge. `done_o` is then high for exactly one cycle with the result.
- R8: An issue presented while the unit is in `S_EXEC` is ignored. No register changes because of it, and no extra `done_o` follows.
- R9: Any other opcode or function code sets `illegal_o` with `done_o`. `result_o` then reads 0 and no register is written.
- R10: Reset clears every register to zero and clears `done_o`, `illegal_o` and `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Request to start the instruction on `instr_i` |
| instr_i | input | 32 | Instruction word |
| done_o | output | 1 | One-cycle pulse when an instruction retires |
| result_o | output | XLEN (64) | Value computed for the retired instruction |
| illegal_o | output | 1 | Retired instruction was not a supported operate |

## Verification
The bench builds the unit with its default 64-bit data width. At that width, wrap-around at 2^64 and the full-width effect of the inverting logical functions are both visible. Register 31 is the zero register at this width, and an 8-bit literal of 0xFF shows that zero-extension leaves the upper 56 bits clear. Values are read back by running an OR with register 31 into register 31, so the register state is observed only through `result_o`.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int FN_W      = 7;
    localparam int LIT_W     = 8;
    localparam int REGIDX_W  = 5;

    localparam logic [OPC_W-1:0] OPC_ARITH = 6'h10;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h11;

    localparam logic [FN_W-1:0] FN_ADD    = 7'h20;
    localparam logic [FN_W-1:0] FN_SUB    = 7'h29;
    localparam logic [FN_W-1:0] FN_CMPEQ  = 7'h2D;
    localparam logic [FN_W-1:0] FN_AND    = 7'h00;
    localparam logic [FN_W-1:0] FN_ANDNOT = 7'h08;
    localparam logic [FN_W-1:0] FN_OR     = 7'h20;
    localparam logic [FN_W-1:0] FN_ORNOT  = 7'h28;
    localparam logic [FN_W-1:0] FN_XOR    = 7'h40;
    localparam logic [FN_W-1:0] FN_XORNOT = 7'h48;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_CMPEQ,
        OP_AND,
        OP_ANDNOT,
        OP_OR,
        OP_ORNOT,
        OP_XOR,
        OP_XORNOT,
        OP_BAD
    } alu_op_e;

    typedef enum logic [0:0] {
        S_IDLE,
        S_EXEC
    } iop_state_e;

    typedef struct packed {
        logic [REGIDX_W-1:0] src_a;
        logic [REGIDX_W-1:0] src_b;
        logic [REGIDX_W-1:0] dst;
        logic [LIT_W-1:0]    lit;
        logic                use_lit;
        alu_op_e             op;
    } iop_dec_s;

endpackage

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output iop_dec_s           dec
);

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;

    assign opc = instr[31:26];
    assign fn  = instr[11:5];

    // R1: field positions
    always_comb begin
        dec.src_a   = instr[25:21];
        dec.src_b   = instr[20:16];
        dec.lit     = instr[20:13];
        dec.use_lit = instr[12];
        dec.dst     = instr[4:0];
        dec.op      = OP_BAD;
        unique case (opc)
            OPC_ARITH: begin
                unique case (fn)
                    FN_ADD:   dec.op = OP_ADD;
                    FN_SUB:   dec.op = OP_SUB;
                    FN_CMPEQ: dec.op = OP_CMPEQ;
                    default:  dec.op = OP_BAD;
                endcase
            end
            OPC_LOGIC: begin
                unique case (fn)
                    FN_AND:    dec.op = OP_AND;
                    FN_ANDNOT: dec.op = OP_ANDNOT;
                    FN_OR:     dec.op = OP_OR;
                    FN_ORNOT:  dec.op = OP_ORNOT;
                    FN_XOR:    dec.op = OP_XOR;
                    FN_XORNOT: dec.op = OP_XORNOT;
                    default:   dec.op = OP_BAD;
                endcase
            end
            default: dec.op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/iop_regfile.sv
module iop_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic [XLEN-1:0]         rd_a_data,
    output logic [XLEN-1:0]         rd_b_data,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [XLEN-1:0]         wr_data
);

    localparam int AW       = $clog2(NREG);
    localparam int ZERO_IDX = NREG - 1;

    logic [XLEN-1:0] cells [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        if (i == ZERO_IDX) begin : g_zero
            // R2: hardwired zero, writes dropped
            assign cells[i] = '0;
        end else begin : g_store
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == AW'(i))) begin
                    q <= wr_data;
                end
            end
            assign cells[i] = q;
        end
    end

    assign rd_a_data = cells[rd_a_idx];
    assign rd_b_data = cells[rd_b_idx];

endmodule

// File: rtl/iop_alu.sv
module iop_alu
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            bad
);

    always_comb begin
        bad = 1'b0;
        y   = '0;
        unique case (op)
            OP_ADD:    y = a + b;
            OP_SUB:    y = a - b;
            OP_CMPEQ:  y = {{(XLEN-1){1'b0}}, (a == b)};
            OP_AND:    y = a & b;
            OP_ANDNOT: y = a & ~b;
            OP_OR:     y = a | b;
            OP_ORNOT:  y = a | ~b;
            OP_XOR:    y = a ^ b;
            OP_XORNOT: y = a ^ ~b;
            default:   bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/iop_unit.sv
module iop_unit
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [31:0]        instr_i,
    output logic               done_o,
    output logic [XLEN-1:0]    result_o,
    output logic               illegal_o
);

    localparam int NREG = 1 << REGIDX_W;

    iop_state_e        state_q, state_d;
    logic [INSTR_W-1:0] instr_q;
    iop_dec_s          dec;
    logic [XLEN-1:0]   opnd_a, reg_b, opnd_b, alu_y;
    logic              alu_bad;
    logic              wr_en;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            instr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && issue_i) begin
                instr_q <= instr_i;
            end
        end
    end

    // Transitions: ACCEPT (IDLE->EXEC), RETIRE (EXEC->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (issue_i) state_d = S_EXEC;
            S_EXEC:  state_d = S_IDLE;   // R8: issue ignored here
            default: state_d = S_IDLE;
        endcase
    end

    iop_decode u_dec (
        .instr (instr_q),
        .dec   (dec)
    );

    iop_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (dec.src_a),
        .rd_b_idx  (dec.src_b),
        .rd_a_data (opnd_a),
        .rd_b_data (reg_b),
        .wr_en     (wr_en),
        .wr_idx    (dec.dst),
        .wr_data   (alu_y)
    );

    // R3: zero-extended literal replaces second source
    assign opnd_b = dec.use_lit ? {{(XLEN-LIT_W){1'b0}}, dec.lit} : reg_b;

    iop_alu #(.XLEN(XLEN)) u_alu (
        .op  (dec.op),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (alu_y),
        .bad (alu_bad)
    );

    assign wr_en = (state_q == S_EXEC) && !alu_bad;

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            done_o <= (state_q == S_EXEC);
            if (state_q == S_EXEC) begin
                result_o  <= alu_bad ? '0 : alu_y;
                illegal_o <= alu_bad;
            end else begin
                illegal_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iop_unit_chk.sv
module iop_unit_chk
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_exec,
    input logic                done,
    input logic                illegal,
    input logic [XLEN-1:0]     result,
    input logic [REGIDX_W-1:0] rd_a_idx,
    input logic [XLEN-1:0]     rd_a_data,
    input logic                use_lit,
    input logic [XLEN-1:0]     opnd_b,
    input alu_op_e             op,
    input logic [XLEN-1:0]     alu_y
);

    assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '1) |-> (rd_a_data == '0));

    assert_lit_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && use_lit) |-> (opnd_b[XLEN-1:LIT_W] == '0));

    assert_cmpeq_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == OP_CMPEQ) |-> (alu_y[XLEN-1:1] == '0));

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_exec));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_exec_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec |=> !in_exec);

    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (result == '0));

endmodule

bind iop_unit iop_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_exec   (state_q == S_EXEC),
    .done      (done_o),
    .illegal   (illegal_o),
    .result    (result_o),
    .rd_a_idx  (dec.src_a),
    .rd_a_data (opnd_a),
    .use_lit   (dec.use_lit),
    .opnd_b    (opnd_b),
    .op        (dec.op),
    .alu_y     (alu_y)
);

// File: tb/iop_unit_test.sv
module iop_unit_test;

    localparam int XLEN = 64;
    localparam logic [5:0] A_OP = 6'h10;
    localparam logic [5:0] L_OP = 6'h11;
    localparam logic [6:0] F_ADD = 7'h20, F_SUB = 7'h29, F_CEQ = 7'h2D;
    localparam logic [6:0] F_AND = 7'h00, F_BIC = 7'h08, F_OR = 7'h20;
    localparam logic [6:0] F_ORN = 7'h28, F_XOR = 7'h40, F_XNR = 7'h48;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    // R1: field layout used to build words
    function automatic logic [31:0] er(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                       logic [6:0] fn, logic [4:0] c);
        return {op, a, b, 3'b000, 1'b0, fn, c};
    endfunction

    function automatic logic [31:0] el(logic [5:0] op, logic [4:0] a, logic [7:0] lit,
                                       logic [6:0] fn, logic [4:0] c);
        return {op, a, lit, 1'b1, fn, c};
    endfunction

    localparam int NV = 19;
    localparam logic [31:0] V_INS [NV] = '{
        el(A_OP, 31, 8'd3,   F_ADD, 1),   // R3 R4: R1 = 3
        er(A_OP, 1, 31,      F_ADD, 2),   // R2 R4: R2 = 3
        el(A_OP, 31, 8'd3,   F_CEQ, 0),   // R5: 0 == 3 -> 0
        el(A_OP, 31, 8'd1,   F_SUB, 3),   // R4: wrap -> all ones
        el(A_OP, 3, 8'd2,    F_ADD, 4),   // R4: wrap -> 1
        er(A_OP, 1, 2,       F_CEQ, 5),   // R5: equal -> 1
        el(A_OP, 31, 8'hA5,  F_ADD, 6),   // R3
        er(L_OP, 3, 6,       F_AND, 7),   // R6
        er(L_OP, 3, 6,       F_BIC, 8),   // R6
        el(L_OP, 6, 8'h5A,   F_OR,  9),   // R6
        er(L_OP, 31, 6,      F_ORN, 10),  // R6
        er(L_OP, 9, 6,       F_XOR, 11),  // R6
        el(L_OP, 9, 8'h0F,   F_XNR, 12),  // R6
        er(A_OP, 1, 4,       F_SUB, 13),  // R4
        el(A_OP, 1, 8'd7,    F_ADD, 31),  // R2: write to zero reg
        er(A_OP, 31, 31,     F_ADD, 14),  // R2: still zero
        er(A_OP, 4, 3,       F_SUB, 15),  // R4: 1 - (-1)
        er(A_OP, 3, 3,       F_ADD, 16),  // R4: wrap
        el(A_OP, 31, 8'hFF,  F_ADD, 17)   // R3: zero extension
    };
    localparam logic [63:0] V_EXP [NV] = '{
        64'd3, 64'd3, 64'd0, ONES, 64'd1, 64'd1, 64'hA5, 64'hA5,
        64'hFFFF_FFFF_FFFF_FF5A, 64'hFF, 64'hFFFF_FFFF_FFFF_FF5A, 64'h5A,
        64'hFFFF_FFFF_FFFF_FF0F, 64'd2, 64'd10, 64'd0, 64'd2,
        64'hFFFF_FFFF_FFFF_FFFE, 64'hFF
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic            done_o;
    logic [XLEN-1:0] result_o;
    logic            illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iop_unit #(.XLEN(XLEN)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .instr_i   (instr_i),
        .done_o    (done_o),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one word; sample in the cycle done_o is expected (R7).
    task automatic run(logic [31:0] w, output logic [63:0] res,
                       output logic ill, output logic dn);
        @(negedge clk);
        issue_i = 1'b1;
        instr_i = w;
        @(negedge clk);
        issue_i = 1'b0;
        @(negedge clk);
        res = result_o;
        ill = illegal_o;
        dn  = done_o;
    endtask

    task automatic peek(logic [4:0] r, output logic [63:0] v);
        logic i, d;
        run(er(L_OP, r, 31, F_OR, 31), v, i, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [63:0] res;
        logic ill, dn;

        do_reset();
        // R10: reset state
        check("R10 done", 64'(done_o), 64'd0);
        check("R10 illegal", 64'(illegal_o), 64'd0);
        check("R10 result", result_o, 64'd0);
        peek(5'd20, res);
        check("R10 reg cleared", res, 64'd0);

        for (int k = 0; k < NV; k++) begin
            run(V_INS[k], res, ill, dn);
            check($sformatf("vector %0d (R1 R7)", k), res, V_EXP[k]);
            check($sformatf("vector %0d done R7", k), 64'(dn), 64'd1);
            check($sformatf("vector %0d legal R9", k), 64'(ill), 64'd0);
        end

        // R7: done lasts one cycle
        @(negedge clk);
        check("R7 done single pulse", 64'(done_o), 64'd0);

        // R2: register 31 unchanged after a write
        peek(5'd31, res);
        check("R2 zero reg read", res, 64'd0);
        peek(5'd13, res);
        check("R1 stored value", res, 64'd2);

        // R8: second issue during S_EXEC ignored
        @(negedge clk);
        issue_i = 1'b1;
        instr_i = el(A_OP, 31, 8'd9, F_ADD, 20);
        @(negedge clk);
        instr_i = el(A_OP, 31, 8'h33, F_ADD, 20);
        @(negedge clk);
        issue_i = 1'b0;
        check("R8 first result", result_o, 64'd9);
        @(negedge clk);
        check("R8 no extra done", 64'(done_o), 64'd0);
        peek(5'd20, res);
        check("R8 reg keeps first", res, 64'd9);

        // R9: unknown opcode and unknown function
        run(el(6'h12, 31, 8'd5, F_ADD, 20), res, ill, dn);
        check("R9 bad opcode flag", 64'(ill), 64'd1);
        check("R9 bad opcode result", res, 64'd0);
        run(el(A_OP, 31, 8'd5, 7'h7F, 20), res, ill, dn);
        check("R9 bad func flag", 64'(ill), 64'd1);
        check("R9 bad func done", 64'(dn), 64'd1);
        peek(5'd20, res);
        check("R9 no write", res, 64'd9);

        // R1: with literal flag clear, bits 15:13 do not matter
        run({A_OP, 5'd1, 5'd2, 3'b111, 1'b0, F_ADD, 5'd31}, res, ill, dn);
        check("R1 register form", res, 64'd6);

        // R10: mid-run reset clears registers
        do_reset();
        peek(5'd20, res);
        check("R10 reg cleared again", res, 64'd0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule